// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects maskable interrupt requests for a small processor and picks the one to present. Every source has a one-byte control register on a plain register bus. The register holds a 3-bit priority level and a pending flag. Sources on external pins also hold a trigger-edge select bit. The low source indices belong to the external pins and the rest belong to internal peripherals. Each external pin passes through a two-stage synchronizer and then an edge detector. Each internal peripheral sets its flag with a pulse that lasts one clock.

The arbiter sees the registered flags and levels, the global interrupt-enable input and the processor's current priority level. From these it drives, purely combinationally, a request line, the index of the winning source and that source's level. When the processor asserts the acknowledge input, the winner's pending flag is cleared. Software can clear a pending flag but can never set one. Register reads are combinational from the address. Writes are single-cycle strobes. The register bus, the interrupt outputs and the acknowledge are plain control pins with no handshake, so the block never applies back-pressure.

Top module: `icu_top`

## Requirements
- R1: Bits [2:0] of a source's register hold its priority level and read back as written. Level 0 means the source never raises `irq`.
- R2: Bit 3 is the pending flag. Only hardware sets it. Writing 0 to bit 3 clears it, and writing 1 to bit 3 leaves it unchanged.
- R3: On external sources, bit 4 selects the trigger edge, 1 for rising and 0 for falling. An edge of the other direction sets nothing. After the pin changes, the flag reads 1 after the third rising clock edge and still reads 0 after the second.
- R4: If an internal source's pulse input is high at a rising clock edge, that edge sets the source's pending flag.
- R5: Some bits always read 0 and ignore writes: bits [7:5] of external registers, bits [7:4] of internal registers, and every bit at an address of N or above.
- R6: After reset every register reads 0x00 and `irq` is low.
- R7: A source is eligible only when its flag is set, `ie_flag` is 1, and its level is strictly greater than `cpu_ipl`. `irq` is high exactly when at least one source is eligible.
- R8: Among eligible sources the highest level wins, and a tie goes to the lowest index. `irq_src` and `irq_lvl` show the winner.
- R9: If a hardware set of a flag and a clear of the same flag land in the same cycle, the flag ends up set. The clear may come from a register write or from an acknowledge.
- R10: An acknowledge while `irq` is high clears only the winner's flag. An acknowledge while `irq` is low changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | AW | Register index, which equals the source index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| ext_pin | input | N_EXT | Asynchronous external interrupt pins |
| int_pulse | input | N-N_EXT | Request pulses from internal peripherals |
| ie_flag | input | 1 | Global maskable interrupt enable |
| cpu_ipl | input | 3 | Current processor priority level |
| irq | output | 1 | At least one source is eligible |
| irq_src | output | IW | Index of the winning source |
| irq_lvl | output | 3 | Level of the winning source |
| irq_ack | input | 1 | Acknowledge, which clears the winner's flag |

## Verification
The bench goes after these corner cases:
- Level ties. An arbiter that scanned with `>=` would report the higher index.
- A level equal to `cpu_ipl`. A non-strict compare would raise `irq` when it should stay low.
- A write to the pending bit that lands in the same cycle as a hardware set. A design that gives the write priority would lose the request.
- A write of 1 to the pending bit. A design that treats that bit as ordinary storage would create a request from software.
- An edge of the wrong polarity on an external pin, and the exact cycle on which a pin edge becomes visible. A missing synchronizer stage, or an inverted polarity select, shows up as the wrong cycle or a missing request.
- An acknowledge with two sources pending. A design that clears more than the winner would drop the loser.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int LVL_W   = 3;
  localparam int REQ_BIT = 3;
  localparam int POL_BIT = 4;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/icu_edge_sync.sv
module icu_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign hit = rise_sel ? (sync_q & ~prev_q) : (~sync_q & prev_q);
endmodule

// File: rtl/icu_src_reg.sv
module icu_src_reg
  import icu_pkg::*;
#(
  parameter bit HAS_POL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sel,
  input  logic [7:0] wdata,
  input  logic       hw_set,
  input  logic       ack_clr,
  output lvl_t       lvl,
  output logic       req,
  output logic       pol,
  output logic [7:0] rdata
);
  lvl_t lvl_q;
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      req_q <= 1'b0;
    end else begin
      if (wr_sel) lvl_q <= wdata[LVL_W-1:0];
      if (hw_set)
        req_q <= 1'b1;
      else if (ack_clr || (wr_sel && !wdata[REQ_BIT]))
        req_q <= 1'b0;
    end
  end

  generate
    if (HAS_POL) begin : g_pol
      logic pol_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      pol_q <= 1'b0;
        else if (wr_sel) pol_q <= wdata[POL_BIT];
      end
      assign pol = pol_q;
    end else begin : g_nopol
      assign pol = 1'b0;
    end
  endgenerate

  assign lvl   = lvl_q;
  assign req   = req_q;
  assign rdata = {3'b000, pol, req_q, lvl_q};
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter
  import icu_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0][LVL_W-1:0] lvls,
  input  logic [N-1:0]            reqs,
  input  logic                    ie,
  input  lvl_t                    ipl,
  output logic                    any,
  output logic [IW-1:0]           win_idx,
  output lvl_t                    win_lvl
);
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (reqs[i] && ie && (lvls[i] > ipl) && (lvls[i] > win_lvl)) begin
        any     = 1'b1;
        win_idx = IW'(i);
        win_lvl = lvls[i];
      end
    end
  end
endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int N     = 8,
  parameter int N_EXT = 3,
  parameter int AW    = 4,
  localparam int N_INT = N - N_EXT,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [N_INT-1:0] int_pulse,
  input  logic             ie_flag,
  input  logic [2:0]       cpu_ipl,
  output logic             irq,
  output logic [IW-1:0]    irq_src,
  output logic [2:0]       irq_lvl,
  input  logic             irq_ack
);
  logic [N-1:0][LVL_W-1:0] lvl_q;
  logic [N-1:0]            req_q;
  logic [N-1:0]            pol_q;
  logic [N-1:0]            hw_set;
  logic [N-1:0]            ack_clr;
  logic [N-1:0]            wr_sel;
  logic [N-1:0][7:0]       rd_each;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_src
      assign wr_sel[i]  = reg_wr && (reg_addr == AW'(i));
      assign ack_clr[i] = irq_ack && irq && (irq_src == IW'(i));
      if (i < N_EXT) begin : g_ext
        icu_edge_sync u_sync (
          .clk(clk), .rst_n(rst_n), .pin(ext_pin[i]),
          .rise_sel(pol_q[i]), .hit(hw_set[i])
        );
      end else begin : g_int
        assign hw_set[i] = int_pulse[i-N_EXT];
      end
      icu_src_reg #(.HAS_POL(i < N_EXT)) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel[i]), .wdata(reg_wdata),
        .hw_set(hw_set[i]), .ack_clr(ack_clr[i]),
        .lvl(lvl_q[i]), .req(req_q[i]), .pol(pol_q[i]), .rdata(rd_each[i])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = 8'h00;
    for (int k = 0; k < N; k++)
      if (reg_addr == AW'(k)) reg_rdata = rd_each[k];
  end

  icu_arbiter #(.N(N), .IW(IW)) u_arb (
    .lvls(lvl_q), .reqs(req_q), .ie(ie_flag), .ipl(cpu_ipl),
    .any(irq), .win_idx(irq_src), .win_lvl(irq_lvl)
  );
endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [IW-1:0] irq_src,
  input logic [2:0]    irq_lvl,
  input logic          irq_ack,
  input logic          ie_flag,
  input logic [2:0]    cpu_ipl,
  input logic [7:0]    reg_rdata,
  input logic [N-1:0]  req_vec,
  input logic [N-1:0]  hw_set
);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_flag && irq_lvl > cpu_ipl));
  // R1
  irq_lvl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_lvl != 3'd0));
  // R8
  winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> req_vec[irq_src]);
  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack && !hw_set[irq_src]) |=> !req_vec[$past(irq_src)]);
  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:5] == 3'b000);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_flag
      // R9
      hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set[g] |=> req_vec[g]);
      // R2
      only_hw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_set[g] && !req_vec[g]) |=> !req_vec[g]);
    end
  endgenerate
endmodule

bind icu_top icu_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .irq_src(irq_src), .irq_lvl(irq_lvl),
  .irq_ack(irq_ack), .ie_flag(ie_flag), .cpu_ipl(cpu_ipl),
  .reg_rdata(reg_rdata), .req_vec(req_q), .hw_set(hw_set)
);

// File: tb/tb_icu_top.sv
module tb_icu_top;
  localparam int N = 8, N_EXT = 3, AW = 4, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [N_EXT-1:0] ext_pin = '0;
  logic [N-N_EXT-1:0] int_pulse = '0;
  logic ie_flag = 1'b0, irq, irq_ack = 1'b0;
  logic [2:0] cpu_ipl = '0, irq_lvl;
  logic [IW-1:0] irq_src;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  icu_top #(.N(N), .N_EXT(N_EXT), .AW(AW)) dut (.*);

  typedef struct packed {
    logic [23:0] lv;   // level of source s at [3s+2:3s]
    logic [4:0]  pend; // internal pulses, bit j -> source 3+j
    logic        ie;
    logic [2:0]  ipl;
    logic        eirq;
    logic [2:0]  esrc;
    logic [2:0]  elvl;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{{3'd0,3'd0,3'd0,3'd5,3'd2,3'd0,3'd0,3'd0}, 5'b00011, 1'b1, 3'd0, 1'b1, 3'd4, 3'd5},
    '{{3'd0,3'd0,3'd0,3'd5,3'd5,3'd0,3'd0,3'd0}, 5'b00011, 1'b1, 3'd0, 1'b1, 3'd3, 3'd5},
    '{{3'd0,3'd0,3'd0,3'd5,3'd5,3'd0,3'd0,3'd0}, 5'b00011, 1'b0, 3'd0, 1'b0, 3'd0, 3'd0},
    '{{3'd0,3'd0,3'd0,3'd0,3'd4,3'd0,3'd0,3'd0}, 5'b00001, 1'b1, 3'd4, 1'b0, 3'd0, 3'd0},
    '{{3'd0,3'd0,3'd0,3'd0,3'd4,3'd0,3'd0,3'd0}, 5'b00001, 1'b1, 3'd3, 1'b1, 3'd3, 3'd4},
    '{{3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0,3'd0}, 5'b00100, 1'b1, 3'd0, 1'b0, 3'd0, 3'd0},
    '{{3'd7,3'd7,3'd0,3'd0,3'd1,3'd0,3'd0,3'd0}, 5'b11001, 1'b1, 3'd6, 1'b1, 3'd6, 3'd7},
    '{{3'd7,3'd6,3'd5,3'd4,3'd3,3'd0,3'd0,3'd0}, 5'b00000, 1'b1, 3'd0, 1'b0, 3'd0, 3'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_now(input int a, output logic [7:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk); int_pulse = m;
    @(negedge clk); int_pulse = '0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: reset state
    for (int s = 0; s < N; s++) begin
      rd_now(s, d); check("R6 reset reg", d, 8'h00);
    end
    check("R6 irq after reset", irq, 1'b0);

    // R7 R8 R1: arbitration table
    for (int v = 0; v < 8; v++) begin
      ie_flag = 1'b0;
      for (int s = 0; s < N; s++) wr(s, 8'h00);
      for (int s = 0; s < N; s++) wr(s, {5'b0, VEC[v].lv[3*s +: 3]});
      pulse(VEC[v].pend);
      ie_flag = VEC[v].ie; cpu_ipl = VEC[v].ipl;
      #1;
      check($sformatf("R7 irq vec%0d", v), irq, VEC[v].eirq);
      if (VEC[v].eirq) begin
        check($sformatf("R8 src vec%0d", v), irq_src, VEC[v].esrc);
        check($sformatf("R8 lvl vec%0d", v), irq_lvl, VEC[v].elvl);
      end
    end

    ie_flag = 1'b0; cpu_ipl = 3'd0;
    for (int s = 0; s < N; s++) wr(s, 8'h00);

    // R2: writing 1 to pending bit does not set it
    wr(3, 8'h0F); @(negedge clk); rd_now(3, d);
    check("R2 write one no set", d, 8'h07);
    // R1 R4: pulse sets, level reads back
    pulse(5'b00001); rd_now(3, d);
    check("R4 pulse sets flag", d, 8'h0F);
    // R2: writing 0 clears
    wr(3, 8'h07); @(negedge clk); rd_now(3, d);
    check("R2 write zero clears", d, 8'h07);
    // R9: hw set beats same-cycle sw clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd3; reg_wdata = 8'h05; int_pulse = 5'b00001;
    @(negedge clk);
    reg_wr = 1'b0; int_pulse = '0;
    rd_now(3, d);
    check("R9 hw set wins", d, 8'h0D);

    // R10: ack ignored while irq low
    ie_flag = 1'b0; ack(); rd_now(3, d);
    check("R10 ack with irq low", d, 8'h0D);
    // R10: ack clears only winner
    wr(4, 8'h06); pulse(5'b00010);
    ie_flag = 1'b1; #1;
    check("R10 winner before ack", irq_src, 3'd4);
    ack(); ie_flag = 1'b0;
    rd_now(4, d); check("R10 winner cleared", d, 8'h06);
    rd_now(3, d); check("R10 loser kept", d, 8'h05 | 8'h08);

    // R9: hw set beats same-cycle ack
    ie_flag = 1'b1;
    @(negedge clk); irq_ack = 1'b1; int_pulse = 5'b00001;
    @(negedge clk); irq_ack = 1'b0; int_pulse = '0;
    ie_flag = 1'b0;
    rd_now(3, d); check("R9 hw set beats ack", d, 8'h0D);

    // R3: rising edge on source 0, timing
    wr(0, 8'h13);
    @(negedge clk); ext_pin[0] = 1'b1;
    repeat (2) @(negedge clk); rd_now(0, d);
    check("R3 not yet after two edges", d, 8'h13);
    @(negedge clk); rd_now(0, d);
    check("R3 rising sets on third edge", d, 8'h1B);
    wr(0, 8'h13);
    @(negedge clk); ext_pin[0] = 1'b0;
    repeat (5) @(negedge clk); rd_now(0, d);
    check("R3 falling ignored when rising selected", d, 8'h13);
    // R3: falling select on source 1
    wr(1, 8'h02);
    @(negedge clk); ext_pin[1] = 1'b1;
    repeat (5) @(negedge clk); rd_now(1, d);
    check("R3 rising ignored when falling selected", d, 8'h02);
    @(negedge clk); ext_pin[1] = 1'b0;
    repeat (3) @(negedge clk); rd_now(1, d);
    check("R3 falling sets", d, 8'h0A);

    // R5: unassigned bits
    wr(2, 8'hF5); @(negedge clk); rd_now(2, d);
    check("R5 ext upper bits zero", d, 8'h15);
    wr(5, 8'hF3); @(negedge clk); rd_now(5, d);
    check("R5 int upper bits zero", d, 8'h03);
    wr(9, 8'hFF); @(negedge clk); rd_now(9, d);
    check("R5 out of range reads zero", d, 8'h00);
    // R1: level 0 disables
    wr(6, 8'h00); pulse(5'b01000); ie_flag = 1'b1; cpu_ipl = 3'd7;
    #1; check("R1 nothing above ipl 7", irq, 1'b0);
    cpu_ipl = 3'd0; wr(3, 8'h00); wr(0, 8'h00); wr(1, 8'h00); #1;
    check("R1 level zero pending not raised", irq, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule